// File: doc/BRIEF.md
# Mailbox Boot Loader Engine

This block stands in for a small boot ROM on the target side of a host/target link. It is a hardware sequencer. A host reaches it through four byte-wide mailbox ports. Each port has its own host-to-target register, which the host writes, and its own target-to-host register, which the engine writes and the host reads. The engine reaches a 64K x 8 synchronous single-port RAM through an address, write data, write enable and read data with one cycle of read latency.

After reset the engine zeroes the bottom of RAM and then posts a ready signature. It waits for a start command and then takes a 16-bit entry address and a 16-bit mode word. A nonzero upper mode byte makes it receive a byte stream into RAM. Each byte is tagged with an index that the engine echoes back. A zero upper mode byte makes it issue a start pulse carrying the 16-bit address held in RAM bytes 0 and 1, after which it halts until the next reset.

Top module: `mbx_boot_engine`

## Requirements
- R1: After reset the engine writes 0x00 to RAM addresses 0xEF, 0xEE, ..., 0x00, one address per cycle in descending order, 240 writes in all, before any other RAM or port activity.
- R2: When clearing ends, outgoing port 0 becomes 0xAA and outgoing port 1 then becomes 0xBB.
- R3: The engine does nothing further until incoming port 0 holds 0xCC. It then waits until incoming port 0 holds any other value, and that value is the mode low byte. While it waits, no RAM write and no outgoing port change takes place.
- R4: The entry address is taken from incoming port 2 (low byte) and incoming port 3 (high byte) and written to RAM address 0x0000 (low) and 0x0001 (high).
- R5: The mode low byte is the value of incoming port 0 at capture time and is echoed to outgoing port 0. The mode high byte is the value of incoming port 1.
- R6: A zero mode high byte makes the engine read RAM 0x0000/0x0001 and drive `start` high for exactly one cycle, with `start_addr` set to that 16-bit value. After that it performs no RAM write, port write or further pulse, whatever the host does, until reset.
- R7: A nonzero mode high byte loads the base pointer from RAM 0x0000/0x0001. The engine then waits until incoming port 0 is nonzero and takes that value as the starting index.
- R8: When incoming port 0 equals the current index, the engine writes incoming port 1 to RAM at base pointer + index, echoes the index on outgoing port 0, and increments the index. While incoming port 0 differs from the index, nothing is written and outgoing port 0 is unchanged.
- R9: When the index wraps from 0xFF to 0x00, the base pointer high byte is incremented and written to RAM 0x0001. If bit 7 of the new value is set, the engine goes straight back to entry-address and mode capture without waiting for 0xCC. Otherwise it continues receiving at index 0x00.
- R10: A host write to an incoming port is seen by the engine from the next clock edge. An engine write to an outgoing port appears on `t2h_ports` at the next clock edge. Port n occupies bits [8n+7:8n].
- R11: During reset all outgoing ports read 0x00 and `start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host write strobe for an incoming port |
| h_sel | input | 2 | Incoming port number for the host write |
| h_wdata | input | 8 | Host write data |
| t2h_ports | output | 32 | Outgoing ports, port n at bits [8n+7:8n] |
| mem_addr | output | 16 | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | 8 | RAM read data, one cycle after the address |
| start | output | 1 | One-cycle execution pulse |
| start_addr | output | 16 | Execution address, valid with `start` |

## Verification
The assertions assume that the host writes at most one incoming port per cycle and never pulses `h_we` with an unknown `h_sel`. They also assume that the RAM returns on `mem_rdata` the byte last written to the address presented one cycle earlier. The bench drives the host side through a single write task, one register per cycle. Its RAM model returns data one cycle after the address and keeps unwritten locations at zero. The host-side ordering never relies on an exact cycle count inside the engine: the bench always waits for an echo on outgoing port 0 before sending the next stimulus. Before sending the byte that causes the final wrap, it preloads the ports that the engine reads right away.

// File: rtl/mbx_boot_pkg.sv
package mbx_boot_pkg;
    localparam int MBX_DW    = 8;
    localparam int MBX_AW    = 16;
    localparam int MBX_NPORT = 4;
    localparam int MBX_SELW  = $clog2(MBX_NPORT);

    typedef logic [MBX_DW-1:0] byte_t;
    typedef logic [MBX_AW-1:0] addr_t;

    typedef enum logic [3:0] {
        ST_CLEAR,
        ST_SIG_LO,
        ST_SIG_HI,
        ST_WAIT_CMD,
        ST_WAIT_MODE,
        ST_ENT_LO,
        ST_ENT_HI,
        ST_RD0,
        ST_RD1,
        ST_RD2,
        ST_UP_START,
        ST_UP_WAIT,
        ST_UP_BUMP,
        ST_HALT
    } boot_st_e;

    typedef struct packed {
        boot_st_e st;
        byte_t    cnt;
        byte_t    idx;
        addr_t    ptr;
        addr_t    entry;
        logic     exec;
        logic     start;
        addr_t    saddr;
    } boot_state_s;
endpackage

// File: rtl/mbx_port_bank.sv
module mbx_port_bank
    import mbx_boot_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        h_we,
    input  logic [MBX_SELW-1:0]         h_sel,
    input  byte_t                       h_wdata,
    input  logic                        t_we,
    input  logic [MBX_SELW-1:0]         t_sel,
    input  byte_t                       t_wdata,
    output logic [MBX_NPORT*MBX_DW-1:0] in_flat,
    output logic [MBX_NPORT*MBX_DW-1:0] out_flat
);
    byte_t in_d  [MBX_NPORT];
    byte_t in_q  [MBX_NPORT];
    byte_t out_d [MBX_NPORT];
    byte_t out_q [MBX_NPORT];

    for (genvar p = 0; p < MBX_NPORT; p++) begin : g_port
        always_comb begin
            in_d[p]  = in_q[p];
            out_d[p] = out_q[p];
            if (h_we && (h_sel == MBX_SELW'(p))) in_d[p]  = h_wdata;
            if (t_we && (t_sel == MBX_SELW'(p))) out_d[p] = t_wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                in_q[p]  <= '0;
                out_q[p] <= '0;
            end else begin
                in_q[p]  <= in_d[p];
                out_q[p] <= out_d[p];
            end
        end

        assign in_flat [p*MBX_DW +: MBX_DW] = in_q[p];
        assign out_flat[p*MBX_DW +: MBX_DW] = out_q[p];
    end

    AST_HOST_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        h_we |=> in_q[$past(h_sel)] == $past(h_wdata)); // R10
    AST_TGT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        t_we |=> out_q[$past(t_sel)] == $past(t_wdata)); // R10
endmodule

// File: rtl/mbx_boot_fsm.sv
module mbx_boot_fsm
    import mbx_boot_pkg::*;
#(
    parameter byte_t CLEAR_TOP = 8'hEF,
    parameter byte_t SIG_LO    = 8'hAA,
    parameter byte_t SIG_HI    = 8'hBB,
    parameter byte_t CMD_GO    = 8'hCC
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [MBX_NPORT*MBX_DW-1:0] in_flat,
    output logic                        t_we,
    output logic [MBX_SELW-1:0]         t_sel,
    output byte_t                       t_wdata,
    output addr_t                       mem_addr,
    output byte_t                       mem_wdata,
    output logic                        mem_we,
    input  byte_t                       mem_rdata,
    output logic                        start,
    output addr_t                       start_addr
);
    localparam addr_t PTR_LO_ADDR = addr_t'(0);
    localparam addr_t PTR_HI_ADDR = addr_t'(1);

    boot_state_s s_q, s_d;
    byte_t in0, in1, in2, in3;
    addr_t up_addr;
    byte_t hi_next;

    assign in0 = in_flat[0*MBX_DW +: MBX_DW];
    assign in1 = in_flat[1*MBX_DW +: MBX_DW];
    assign in2 = in_flat[2*MBX_DW +: MBX_DW];
    assign in3 = in_flat[3*MBX_DW +: MBX_DW];
    assign up_addr = s_q.ptr + addr_t'(s_q.idx);
    assign hi_next = s_q.ptr[MBX_AW-1 -: MBX_DW] + 1'b1;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        t_we      = 1'b0;
        t_sel     = '0;
        t_wdata   = '0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        unique case (s_q.st)
            ST_CLEAR: begin
                mem_we   = 1'b1;
                mem_addr = addr_t'(s_q.cnt);
                if (s_q.cnt == '0) s_d.st = ST_SIG_LO;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            ST_SIG_LO: begin
                t_we    = 1'b1;
                t_sel   = MBX_SELW'(0);
                t_wdata = SIG_LO;
                s_d.st  = ST_SIG_HI;
            end
            ST_SIG_HI: begin
                t_we    = 1'b1;
                t_sel   = MBX_SELW'(1);
                t_wdata = SIG_HI;
                s_d.st  = ST_WAIT_CMD;
            end
            ST_WAIT_CMD: begin
                if (in0 == CMD_GO) s_d.st = ST_WAIT_MODE;
            end
            ST_WAIT_MODE: begin
                if (in0 != CMD_GO) s_d.st = ST_ENT_LO;
            end
            ST_ENT_LO: begin
                s_d.entry = {in3, in2};
                mem_we    = 1'b1;
                mem_addr  = PTR_LO_ADDR;
                mem_wdata = in2;
                s_d.st    = ST_ENT_HI;
            end
            ST_ENT_HI: begin
                mem_we    = 1'b1;
                mem_addr  = PTR_HI_ADDR;
                mem_wdata = s_q.entry[MBX_AW-1 -: MBX_DW];
                t_we      = 1'b1;
                t_sel     = MBX_SELW'(0);
                t_wdata   = in0;
                s_d.exec  = (in1 == '0);
                s_d.st    = ST_RD0;
            end
            ST_RD0: begin
                mem_addr = PTR_LO_ADDR;
                s_d.st   = ST_RD1;
            end
            ST_RD1: begin
                mem_addr = PTR_HI_ADDR;
                s_d.ptr[MBX_DW-1:0] = mem_rdata;
                s_d.st   = ST_RD2;
            end
            ST_RD2: begin
                if (s_q.exec) begin
                    s_d.start = 1'b1;
                    s_d.saddr = {mem_rdata, s_q.ptr[MBX_DW-1:0]};
                    s_d.st    = ST_HALT;
                end else begin
                    s_d.ptr[MBX_AW-1 -: MBX_DW] = mem_rdata;
                    s_d.st = ST_UP_START;
                end
            end
            ST_UP_START: begin
                if (in0 != '0) begin
                    s_d.idx = in0;
                    s_d.st  = ST_UP_WAIT;
                end
            end
            ST_UP_WAIT: begin
                if (in0 == s_q.idx) begin
                    mem_we    = 1'b1;
                    mem_addr  = up_addr;
                    mem_wdata = in1;
                    t_we      = 1'b1;
                    t_sel     = MBX_SELW'(0);
                    t_wdata   = s_q.idx;
                    s_d.idx   = s_q.idx + 1'b1;
                    if (up_addr == PTR_LO_ADDR) s_d.ptr[MBX_DW-1:0] = in1;
                    if (up_addr == PTR_HI_ADDR) s_d.ptr[MBX_AW-1 -: MBX_DW] = in1;
                    if (s_q.idx == '1) s_d.st = ST_UP_BUMP;
                end
            end
            ST_UP_BUMP: begin
                mem_we    = 1'b1;
                mem_addr  = PTR_HI_ADDR;
                mem_wdata = hi_next;
                s_d.ptr[MBX_AW-1 -: MBX_DW] = hi_next;
                s_d.st    = hi_next[MBX_DW-1] ? ST_ENT_LO : ST_UP_WAIT;
            end
            ST_HALT: begin
                s_d.st = ST_HALT;
            end
            default: s_d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_CLEAR;
            s_q.cnt   <= CLEAR_TOP;
        end else begin
            s_q <= s_d;
        end
    end

    assign start      = s_q.start;
    assign start_addr = s_q.saddr;

    AST_CLEAR_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_CLEAR && mem_addr != '0)
            |=> (mem_we && mem_wdata == '0 && mem_addr == $past(mem_addr) - 1'b1)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_WAIT_CMD || s_q.st == ST_WAIT_MODE) |-> (!mem_we && !t_we)); // R3
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start); // R6
    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> (!mem_we && !t_we && !start)); // R6
    AST_UP_ECHO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_UP_WAIT && t_we) |-> (t_wdata == in0 && mem_wdata == in1)); // R8
endmodule

// File: rtl/mbx_boot_engine.sv
module mbx_boot_engine
    import mbx_boot_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        h_we,
    input  logic [1:0]                  h_sel,
    input  logic [7:0]                  h_wdata,
    output logic [31:0]                 t2h_ports,
    output logic [15:0]                 mem_addr,
    output logic [7:0]                  mem_wdata,
    output logic                        mem_we,
    input  logic [7:0]                  mem_rdata,
    output logic                        start,
    output logic [15:0]                 start_addr
);
    logic [MBX_NPORT*MBX_DW-1:0] in_flat;
    logic                        t_we;
    logic [MBX_SELW-1:0]         t_sel;
    byte_t                       t_wdata;

    mbx_port_bank u_ports (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_we     (h_we),
        .h_sel    (h_sel),
        .h_wdata  (h_wdata),
        .t_we     (t_we),
        .t_sel    (t_sel),
        .t_wdata  (t_wdata),
        .in_flat  (in_flat),
        .out_flat (t2h_ports)
    );

    mbx_boot_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_flat    (in_flat),
        .t_we       (t_we),
        .t_sel      (t_sel),
        .t_wdata    (t_wdata),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_rdata  (mem_rdata),
        .start      (start),
        .start_addr (start_addr)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (t2h_ports == '0 && !start)); // R11
endmodule

// File: tb/sim_mbx_boot_engine.sv
module sim_mbx_boot_engine;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_we = 1'b0;
    logic [1:0]  h_sel = '0;
    logic [7:0]  h_wdata = '0;
    logic [31:0] t2h_ports;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata = '0;
    logic        start;
    logic [15:0] start_addr;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [7:0] bram [int];
    int wr_cnt = 0;
    int clr_cnt = 0, clr_bad = 0;
    logic [7:0] clr_next = 8'hEF;
    bit clr_active = 0;
    int start_cnt = 0;
    logic [15:0] start_seen = '0;
    bit saw_hi80 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_boot_engine u0 (
        .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_sel(h_sel), .h_wdata(h_wdata),
        .t2h_ports(t2h_ports), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .start(start), .start_addr(start_addr)
    );

    // RAM model: one-cycle read latency, unwritten bytes read as zero
    always @(posedge clk) begin
        int a;
        a = int'(mem_addr);
        mem_rdata <= bram.exists(a) ? bram[a] : 8'h00;
        if (rst_n && mem_we) begin
            bram[a] = mem_wdata;
            wr_cnt++;
            if (clr_active) begin
                if (mem_addr != {8'h00, clr_next} || mem_wdata != 8'h00) clr_bad++;
                clr_next = clr_next - 8'd1;
                clr_cnt++;
                if (clr_cnt == 240) clr_active = 0;
            end
            if (mem_addr == 16'h0001 && mem_wdata == 8'h80) saw_hi80 = 1;
        end
        if (rst_n && start) begin
            start_cnt++;
            start_seen = start_addr;
        end
    end

    function automatic logic [7:0] rd(input int a);
        return bram.exists(a) ? bram[a] : 8'h00;
    endfunction

    function automatic logic [7:0] outp(input int n);
        return t2h_ports[n*8 +: 8];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic hwrite(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        h_we = 1'b1; h_sel = sel; h_wdata = d;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic wait_out0(input logic [7:0] v, input string tag);
        int k;
        k = 0;
        while (outp(0) != v && k < 3000) begin
            @(negedge clk);
            k++;
        end
        check(outp(0) == v, tag, outp(0), v);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        h_we = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset state at the ports
        check(t2h_ports == 32'h0, "R11 ports in reset", t2h_ports, 0);
        check(start == 1'b0, "R11 start in reset", start, 0);
        clr_cnt = 0; clr_bad = 0; clr_next = 8'hEF; clr_active = 1;
        wr_cnt = 0; start_cnt = 0; saw_hi80 = 0;
        rst_n = 1'b1;
    endtask

    task automatic t_boot_and_idle();
        do_reset();
        wait_out0(8'hAA, "R2 signature low");
        check(clr_cnt == 240, "R1 clear count", clr_cnt, 240);
        check(clr_bad == 0, "R1 clear order/data", clr_bad, 0);
        check(wr_cnt == 240, "R1 no extra write before signature", wr_cnt, 240);
        repeat (2) @(negedge clk);
        check(outp(1) == 8'hBB, "R2 signature high", outp(1), 8'hBB);
        // R3: non-command values are ignored
        hwrite(2'd0, 8'h12);
        hwrite(2'd1, 8'h34);
        repeat (20) @(negedge clk);
        check(wr_cnt == 240, "R3 no RAM write while idle", wr_cnt, 240);
        check(outp(0) == 8'hAA, "R3 port 0 unchanged while idle", outp(0), 8'hAA);
        // R3: command seen, engine holds until port 0 changes
        hwrite(2'd0, 8'hCC);
        repeat (20) @(negedge clk);
        check(wr_cnt == 240, "R3 hold while command stays", wr_cnt, 240);
    endtask

    task automatic t_upload_then_exec();
        do_reset();
        wait_out0(8'hAA, "R2 signature before upload");
        repeat (2) @(negedge clk);
        hwrite(2'd2, 8'h00);
        hwrite(2'd3, 8'h7F);
        hwrite(2'd1, 8'h01);
        hwrite(2'd0, 8'hCC);
        hwrite(2'd0, 8'h00);
        wait_out0(8'h00, "R5 mode low echo");
        check(rd(0) == 8'h00, "R4 entry low in RAM", rd(0), 8'h00);
        check(rd(1) == 8'h7F, "R4 entry high in RAM", rd(1), 8'h7F);
        hwrite(2'd1, 8'h5A);
        hwrite(2'd0, 8'hFE);
        wait_out0(8'hFE, "R7 start index echo");
        check(rd(16'h7FFE) == 8'h5A, "R8 byte at base+index", rd(16'h7FFE), 8'h5A);
        // R8: mismatching index is ignored
        begin
            int w0;
            w0 = wr_cnt;
            hwrite(2'd1, 8'h77);
            hwrite(2'd0, 8'h33);
            repeat (15) @(negedge clk);
            check(wr_cnt == w0, "R8 no write on mismatch", wr_cnt, w0);
            check(outp(0) == 8'hFE, "R8 no echo on mismatch", outp(0), 8'hFE);
        end
        // preload next entry and mode high before the wrapping byte
        hwrite(2'd2, 8'h34);
        hwrite(2'd3, 8'h12);
        hwrite(2'd1, 8'h00);
        hwrite(2'd0, 8'hFF);
        wait_out0(8'hFF, "R8 last index echo");
        repeat (15) @(negedge clk);
        check(saw_hi80, "R9 pointer high bumped to 0x80", saw_hi80, 1);
        check(rd(1) == 8'h12 && rd(0) == 8'h34, "R9 back to entry capture",
              {rd(1), rd(0)}, 16'h1234);
        check(start_cnt == 1, "R6 one start pulse", start_cnt, 1);
        check(start_seen == 16'h1234, "R6 start address", start_seen, 16'h1234);
    endtask

    task automatic t_wrap_continue();
        do_reset();
        wait_out0(8'hAA, "R2 signature before wrap test");
        repeat (2) @(negedge clk);
        hwrite(2'd2, 8'h00);
        hwrite(2'd3, 8'h20);
        hwrite(2'd1, 8'h01);
        hwrite(2'd0, 8'hCC);
        hwrite(2'd0, 8'h00);
        wait_out0(8'h00, "R5 echo in wrap test");
        hwrite(2'd1, 8'hAB);
        hwrite(2'd0, 8'hFF);
        wait_out0(8'hFF, "R8 echo 0xFF");
        repeat (4) @(negedge clk);
        check(rd(1) == 8'h21, "R9 pointer high incremented", rd(1), 8'h21);
        hwrite(2'd1, 8'hCD);
        hwrite(2'd0, 8'h00);
        wait_out0(8'h00, "R9 echo index 0 after wrap");
        repeat (2) @(negedge clk);
        check(rd(16'h20FF) == 8'hAB, "R8 byte before wrap", rd(16'h20FF), 8'hAB);
        check(rd(16'h2100) == 8'hCD, "R9 byte after wrap at new page", rd(16'h2100), 8'hCD);
        check(start_cnt == 0, "R9 no start while uploading", start_cnt, 0);
    endtask

    task automatic t_direct_exec();
        do_reset();
        wait_out0(8'hAA, "R2 signature before exec");
        repeat (2) @(negedge clk);
        hwrite(2'd2, 8'h78);
        hwrite(2'd3, 8'h56);
        hwrite(2'd1, 8'h00);
        hwrite(2'd0, 8'hCC);
        hwrite(2'd0, 8'h05);
        wait_out0(8'h05, "R5 mode low echo 0x05");
        repeat (10) @(negedge clk);
        check(start_cnt == 1, "R6 direct start pulse", start_cnt, 1);
        check(start_seen == 16'h5678, "R6 direct start address", start_seen, 16'h5678);
        begin
            int w0;
            w0 = wr_cnt;
            hwrite(2'd0, 8'hCC);
            hwrite(2'd0, 8'h09);
            hwrite(2'd1, 8'h01);
            repeat (20) @(negedge clk);
            check(wr_cnt == w0, "R6 halted, no RAM write", wr_cnt, w0);
            check(outp(0) == 8'h05, "R6 halted, port 0 unchanged", outp(0), 8'h05);
            check(start_cnt == 1, "R6 halted, no second pulse", start_cnt, 1);
        end
        // R10: host write reaches the engine at the next edge (seen via echo)
        check(outp(1) == 8'hBB, "R10 port 1 kept", outp(1), 8'hBB);
    endtask

    initial begin
        t_boot_and_idle();
        t_upload_then_exec();
        t_wrap_continue();
        t_direct_exec();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule